// File: doc/BRIEF.md
# Micro-op Group Dispatch Stage

This block sits between an in-order queue of decoded instructions and the out-of-order backend. Each cycle it looks at up to `MAX_W` instructions at the head of the queue and accepts the longest in-order run that fits. A run fits when four budgets all hold: the micro-op budget of the dispatch group, free reorder-buffer entries, free physical registers for renaming, and free entries in the scheduler queue each instruction targets. Load and store instructions also need a load-queue or store-queue entry. The queue pops as many instructions as `in_take` reports, and the accepted instructions appear on a registered dispatch bus one cycle later.

When a valid instruction is refused for any reason other than the group's micro-op budget, the cycle counts as a stall. It is charged to exactly one cause, picked by a fixed priority, in a saturating per-cause counter. A second set of saturating counters forms a histogram of how many micro-ops were dispatched in each cycle. Backend credits arrive as plain free counts, and the block assumes those counts already include everything dispatched in earlier cycles.

Top module: `dispatch_stage`

## Requirements
- R1: Instructions are accepted strictly in slot order, starting at slot 0. Once a slot is refused, or is not valid, no higher slot is accepted in that cycle, even if its resources are available.
- R2: An instruction joins the group only if all of the following hold. First, the group stays within the effective width, counted in micro-ops; the first instruction of a cycle always passes this check, even when it is larger than the width. Second, reorder-buffer entries are available. Third, registers are available (its `nregs` field). Fourth, its scheduler (`sched` field) has one free entry per micro-op. Fifth, a load needs one load-queue entry and a store needs one store-queue entry. All of these counts accumulate over the instructions already accepted in that cycle.
- R3: Each instruction takes as many reorder-buffer entries as its micro-op count (`uops`).
- R4: A `cfg_width` of 0 selects the default width `DEF_W`. A value above `MAX_W` is clamped to `MAX_W`.
- R5: When `cfg_prf_size` is 0, the register pool is unlimited and `reg_free` is ignored.
- R6: A cycle is a stall cycle when the first refused slot is valid and the refusal is not due to the micro-op width check. A stall cycle increments exactly one stall counter. There is no stall when the width check refuses, or when the queue runs out. Counter index: 0 register, 1 reorder buffer, 2 scheduler, 3 load queue, 4 store queue, 5 group restriction.
- R7: When several causes refuse the same instruction, the stall is charged to the cause with the lowest index in the order given in R6.
- R8: An instruction with its `solo` bit set may only be dispatched as the first instruction of a cycle. No instruction follows it in the same cycle. Either refusal is charged to the group-restriction cause, and the width check is applied first.
- R9: Every cycle out of reset increments exactly one histogram bin, the one for the number of micro-ops dispatched. Totals above `MAX_W` go to bin `MAX_W`.
- R10: All counters saturate at all-ones. A synchronous reset clears the counters and the dispatch bus valids.
- R11: One cycle after acceptance, `dsp_valid` has its low `in_take` bits set. Slot k of `dsp_instr` holds the instruction accepted from input slot k. An instruction word is laid out as tag[17:10], uops[9:7], nregs[6:5], sched[4:3], is_load[2], is_store[1], solo[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | clog2(MAX_W+1) | Dispatch width in micro-ops, 0 = default |
| cfg_prf_size | input | FREE_W | Register pool size, 0 = unlimited |
| in_valid | input | MAX_W | Valid per head slot of the queue |
| in_instr | input | MAX_W*18 | Instruction words, slot k at bits [18k+17:18k] |
| in_take | output | clog2(MAX_W+1) | Number of slots accepted this cycle |
| rob_free | input | FREE_W | Free reorder-buffer entries |
| reg_free | input | FREE_W | Free physical registers |
| sched_free | input | NSCH*FREE_W | Free entries per scheduler queue |
| lq_free | input | FREE_W | Free load-queue entries |
| sq_free | input | FREE_W | Free store-queue entries |
| dsp_valid | output | MAX_W | Registered valid per dispatched slot |
| dsp_instr | output | MAX_W*18 | Registered dispatched instruction words |
| stall_cnt | output | 6*CNT_W | Stall counters, cause k at [k*CNT_W +: CNT_W] |
| hist_cnt | output | (MAX_W+1)*CNT_W | Histogram, bin n at [n*CNT_W +: CNT_W] |

## Verification
The hardest situation to reach is an instruction that is refused by several resources at once while an earlier slot in the same cycle has already used part of each budget. Only this case exposes the cause priority and the accumulation across slots. The stimulus table builds such cycles deliberately: a first slot uses exactly the last register, reorder-buffer and scheduler entry, so the second slot fails all three together. Other vectors set the width check against a reorder-buffer shortfall at the same slot, to show that a full group is never charged as a stall. Saturation is reached with a shrunken counter width and a held reorder-buffer shortage.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int TAG_W  = 8;
  localparam int UOP_W  = 3;
  localparam int NREG_W = 2;
  localparam int SCH_W  = 2;
  localparam int NCAUSE = 6;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [UOP_W-1:0]  uops;
    logic [NREG_W-1:0] nregs;
    logic [SCH_W-1:0]  sched;
    logic              is_ld;
    logic              is_st;
    logic              solo;
  } uop_grp_t;

  localparam int INSTR_W = $bits(uop_grp_t);

  typedef enum logic [2:0] {
    CS_REG = 3'd0,
    CS_ROB = 3'd1,
    CS_SCH = 3'd2,
    CS_LDQ = 3'd3,
    CS_STQ = 3'd4,
    CS_GRP = 3'd5
  } cause_e;
endpackage

// File: rtl/dsp_pick.sv
module dsp_pick
  import dsp_pkg::*;
#(
  parameter int MAX_W  = 4,
  parameter int DEF_W  = 2,
  parameter int NSCH   = 3,
  parameter int FREE_W = 8,
  localparam int WSEL_W = $clog2(MAX_W + 1),
  localparam int ACC_W  = FREE_W + 4
) (
  input  logic [WSEL_W-1:0]        cfg_width,
  input  logic [FREE_W-1:0]        cfg_prf_size,
  input  logic [MAX_W-1:0]         in_valid,
  input  logic [MAX_W*INSTR_W-1:0] in_instr,
  input  logic [FREE_W-1:0]        rob_free,
  input  logic [FREE_W-1:0]        reg_free,
  input  logic [NSCH*FREE_W-1:0]   sched_free,
  input  logic [FREE_W-1:0]        lq_free,
  input  logic [FREE_W-1:0]        sq_free,
  output logic [WSEL_W-1:0]        take_n,
  output logic [MAX_W-1:0]         take_mask,
  output logic                     stall_v,
  output cause_e                   stall_c,
  output logic [ACC_W-1:0]         uop_sum
);
  logic [ACC_W-1:0] eff_w;

  always_comb begin
    if (cfg_width == '0)                   eff_w = ACC_W'(DEF_W);
    else if (cfg_width > WSEL_W'(MAX_W))   eff_w = ACC_W'(MAX_W);
    else                                   eff_w = ACC_W'(cfg_width);
  end

  always_comb begin
    logic [WSEL_W-1:0] acc_n;
    logic [ACC_W-1:0]  acc_u, acc_reg, acc_lq, acc_sq;
    logic [ACC_W-1:0]  acc_sch [NSCH];
    logic [ACC_W-1:0]  cur_sch, cur_free;
    logic              sch_hit, solo_prev, stop;
    logic              b_w, b_reg, b_rob, b_sch, b_lq, b_sq, b_grp;
    uop_grp_t          ins;

    acc_n     = '0;
    acc_u     = '0;
    acc_reg   = '0;
    acc_lq    = '0;
    acc_sq    = '0;
    solo_prev = 1'b0;
    stop      = 1'b0;
    take_mask = '0;
    stall_v   = 1'b0;
    stall_c   = CS_REG;
    for (int s = 0; s < NSCH; s++) acc_sch[s] = '0;

    for (int i = 0; i < MAX_W; i++) begin
      ins      = uop_grp_t'(in_instr[i*INSTR_W +: INSTR_W]);
      cur_sch  = '0;
      cur_free = '0;
      sch_hit  = 1'b0;
      for (int s = 0; s < NSCH; s++) begin
        if (ins.sched == SCH_W'(s)) begin
          cur_sch  = acc_sch[s];
          cur_free = ACC_W'(sched_free[s*FREE_W +: FREE_W]);
          sch_hit  = 1'b1;
        end
      end

      b_w   = (acc_n != '0) && ((acc_u + ACC_W'(ins.uops)) > eff_w);
      b_reg = (cfg_prf_size != '0) &&
              ((acc_reg + ACC_W'(ins.nregs)) > ACC_W'(reg_free));
      b_rob = (acc_u + ACC_W'(ins.uops)) > ACC_W'(rob_free);
      b_sch = !sch_hit || ((cur_sch + ACC_W'(ins.uops)) > cur_free);
      b_lq  = ins.is_ld && ((acc_lq + ACC_W'(1)) > ACC_W'(lq_free));
      b_sq  = ins.is_st && ((acc_sq + ACC_W'(1)) > ACC_W'(sq_free));
      b_grp = solo_prev || (ins.solo && (acc_n != '0));

      if (!stop) begin
        if (!in_valid[i] || b_w) begin
          stop = 1'b1;
        end else if (b_reg || b_rob || b_sch || b_lq || b_sq || b_grp) begin
          stop    = 1'b1;
          stall_v = 1'b1;
          if (b_reg)      stall_c = CS_REG;
          else if (b_rob) stall_c = CS_ROB;
          else if (b_sch) stall_c = CS_SCH;
          else if (b_lq)  stall_c = CS_LDQ;
          else if (b_sq)  stall_c = CS_STQ;
          else            stall_c = CS_GRP;
        end else begin
          take_mask[i] = 1'b1;
          acc_n        = acc_n + WSEL_W'(1);
          acc_u        = acc_u + ACC_W'(ins.uops);
          acc_reg      = acc_reg + ACC_W'(ins.nregs);
          if (ins.is_ld) acc_lq = acc_lq + ACC_W'(1);
          if (ins.is_st) acc_sq = acc_sq + ACC_W'(1);
          for (int s = 0; s < NSCH; s++)
            if (ins.sched == SCH_W'(s)) acc_sch[s] = acc_sch[s] + ACC_W'(ins.uops);
          solo_prev = ins.solo;
        end
      end
    end

    take_n  = acc_n;
    uop_sum = acc_u;
  end
endmodule

// File: rtl/dsp_stats.sv
module dsp_stats
  import dsp_pkg::*;
#(
  parameter int MAX_W = 4,
  parameter int CNT_W = 16,
  parameter int ACC_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stall_v,
  input  cause_e                     stall_c,
  input  logic [ACC_W-1:0]           uop_sum,
  output logic [NCAUSE*CNT_W-1:0]    stall_cnt,
  output logic [(MAX_W+1)*CNT_W-1:0] hist_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam int NBIN = MAX_W + 1;

  logic [NBIN-1:0]   bin_hot;
  logic [NCAUSE-1:0] cause_hot;

  always_comb begin
    for (int b = 0; b < NBIN; b++) begin
      if (b == MAX_W) bin_hot[b] = (uop_sum >= ACC_W'(MAX_W));
      else            bin_hot[b] = (uop_sum == ACC_W'(b));
    end
    for (int k = 0; k < NCAUSE; k++)
      cause_hot[k] = stall_v && (stall_c == cause_e'(k));
  end

  genvar k;
  generate
    for (k = 0; k < NCAUSE; k++) begin : g_stall
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)                            cnt <= '0;
        else if (cause_hot[k] && cnt != CMAX) cnt <= cnt + CNT_W'(1);
      end
      assign stall_cnt[k*CNT_W +: CNT_W] = cnt;
    end
    for (k = 0; k < NBIN; k++) begin : g_hist
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (bin_hot[k] && cnt != CMAX) cnt <= cnt + CNT_W'(1);
      end
      assign hist_cnt[k*CNT_W +: CNT_W] = cnt;
    end
  endgenerate
endmodule

// File: rtl/dsp_busreg.sv
module dsp_busreg
  import dsp_pkg::*;
#(
  parameter int MAX_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MAX_W-1:0]         take_mask,
  input  logic [MAX_W*INSTR_W-1:0] in_instr,
  output logic [MAX_W-1:0]         dsp_valid,
  output logic [MAX_W*INSTR_W-1:0] dsp_instr
);
  always_ff @(posedge clk) begin
    if (rst) dsp_valid <= '0;
    else     dsp_valid <= take_mask;
  end

  genvar g;
  generate
    for (g = 0; g < MAX_W; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (take_mask[g]) dsp_instr[g*INSTR_W +: INSTR_W] <= in_instr[g*INSTR_W +: INSTR_W];
      end
    end
  endgenerate
endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
  import dsp_pkg::*;
#(
  parameter int MAX_W  = 4,
  parameter int DEF_W  = 2,
  parameter int NSCH   = 3,
  parameter int FREE_W = 8,
  parameter int CNT_W  = 16,
  localparam int WSEL_W = $clog2(MAX_W + 1),
  localparam int ACC_W  = FREE_W + 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WSEL_W-1:0]          cfg_width,
  input  logic [FREE_W-1:0]          cfg_prf_size,
  input  logic [MAX_W-1:0]           in_valid,
  input  logic [MAX_W*INSTR_W-1:0]   in_instr,
  output logic [WSEL_W-1:0]          in_take,
  input  logic [FREE_W-1:0]          rob_free,
  input  logic [FREE_W-1:0]          reg_free,
  input  logic [NSCH*FREE_W-1:0]     sched_free,
  input  logic [FREE_W-1:0]          lq_free,
  input  logic [FREE_W-1:0]          sq_free,
  output logic [MAX_W-1:0]           dsp_valid,
  output logic [MAX_W*INSTR_W-1:0]   dsp_instr,
  output logic [NCAUSE*CNT_W-1:0]    stall_cnt,
  output logic [(MAX_W+1)*CNT_W-1:0] hist_cnt
);
  logic [MAX_W-1:0] take_mask;
  logic             stall_v;
  cause_e           stall_c;
  logic [ACC_W-1:0] uop_sum;

  dsp_pick #(.MAX_W(MAX_W), .DEF_W(DEF_W), .NSCH(NSCH), .FREE_W(FREE_W)) u_pick (
    .cfg_width(cfg_width), .cfg_prf_size(cfg_prf_size),
    .in_valid(in_valid), .in_instr(in_instr),
    .rob_free(rob_free), .reg_free(reg_free), .sched_free(sched_free),
    .lq_free(lq_free), .sq_free(sq_free),
    .take_n(in_take), .take_mask(take_mask),
    .stall_v(stall_v), .stall_c(stall_c), .uop_sum(uop_sum)
  );

  dsp_stats #(.MAX_W(MAX_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_stats (
    .clk(clk), .rst(rst), .stall_v(stall_v), .stall_c(stall_c),
    .uop_sum(uop_sum), .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
  );

  dsp_busreg #(.MAX_W(MAX_W)) u_bus (
    .clk(clk), .rst(rst), .take_mask(take_mask), .in_instr(in_instr),
    .dsp_valid(dsp_valid), .dsp_instr(dsp_instr)
  );
endmodule

// File: rtl/dispatch_stage_chk.sv
module dispatch_stage_chk
  import dsp_pkg::*;
#(
  parameter int MAX_W  = 4,
  parameter int DEF_W  = 2,
  parameter int NSCH   = 3,
  parameter int FREE_W = 8,
  parameter int CNT_W  = 16,
  localparam int WSEL_W = $clog2(MAX_W + 1),
  localparam int ACC_W  = FREE_W + 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [WSEL_W-1:0]          cfg_width,
  input logic [FREE_W-1:0]          cfg_prf_size,
  input logic [WSEL_W-1:0]          in_take,
  input logic [FREE_W-1:0]          rob_free,
  input logic [FREE_W-1:0]          reg_free,
  input logic [FREE_W-1:0]          lq_free,
  input logic [MAX_W-1:0]           dsp_valid,
  input logic [MAX_W*INSTR_W-1:0]   dsp_instr,
  input logic [NCAUSE*CNT_W-1:0]    stall_cnt,
  input logic [(MAX_W+1)*CNT_W-1:0] hist_cnt
);
  logic [ACC_W-1:0] bus_uops, bus_regs, bus_lds;
  logic [ACC_W-1:0] p_rob, p_reg, p_lq, p_wid;
  logic             p_prf_on;
  logic [NCAUSE*CNT_W-1:0]    p_stall;
  logic [(MAX_W+1)*CNT_W-1:0] p_hist;
  logic [NCAUSE-1:0] s_chg;
  logic [MAX_W:0]    h_chg;

  always_comb begin
    uop_grp_t w;
    bus_uops = '0;
    bus_regs = '0;
    bus_lds  = '0;
    for (int i = 0; i < MAX_W; i++) begin
      w = uop_grp_t'(dsp_instr[i*INSTR_W +: INSTR_W]);
      if (dsp_valid[i]) begin
        bus_uops = bus_uops + ACC_W'(w.uops);
        bus_regs = bus_regs + ACC_W'(w.nregs);
        if (w.is_ld) bus_lds = bus_lds + ACC_W'(1);
      end
    end
    for (int k = 0; k < NCAUSE; k++)
      s_chg[k] = stall_cnt[k*CNT_W +: CNT_W] != p_stall[k*CNT_W +: CNT_W];
    for (int b = 0; b <= MAX_W; b++)
      h_chg[b] = hist_cnt[b*CNT_W +: CNT_W] != p_hist[b*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    p_rob    <= ACC_W'(rob_free);
    p_reg    <= ACC_W'(reg_free);
    p_lq     <= ACC_W'(lq_free);
    p_prf_on <= (cfg_prf_size != '0);
    if (cfg_width == '0)                 p_wid <= ACC_W'(DEF_W);
    else if (cfg_width > WSEL_W'(MAX_W)) p_wid <= ACC_W'(MAX_W);
    else                                 p_wid <= ACC_W'(cfg_width);
    if (rst) begin
      p_stall <= '0;
      p_hist  <= '0;
    end else begin
      p_stall <= stall_cnt;
      p_hist  <= hist_cnt;
    end
  end

  AST_BUS_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid & (dsp_valid + MAX_W'(1))) == '0); // R1
  AST_TAKE_BUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(dsp_valid) == int'($past(in_take)))); // R11
  AST_ROB_CAP: assert property (@(posedge clk) disable iff (rst)
    bus_uops <= p_rob); // R3
  AST_REG_CAP: assert property (@(posedge clk) disable iff (rst)
    p_prf_on |-> (bus_regs <= p_reg)); // R5
  AST_LDQ_CAP: assert property (@(posedge clk) disable iff (rst)
    bus_lds <= p_lq); // R2
  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (rst)
    ($countones(dsp_valid) > 1) |-> (bus_uops <= p_wid)); // R4
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $countones(s_chg) <= 1); // R6
  AST_ONE_BIN: assert property (@(posedge clk) disable iff (rst)
    $countones(h_chg) <= 1); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dsp_valid == '0 && stall_cnt == '0 && hist_cnt == '0)); // R10
endmodule

bind dispatch_stage dispatch_stage_chk #(
  .MAX_W(MAX_W), .DEF_W(DEF_W), .NSCH(NSCH), .FREE_W(FREE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_prf_size(cfg_prf_size),
  .in_take(in_take), .rob_free(rob_free), .reg_free(reg_free), .lq_free(lq_free),
  .dsp_valid(dsp_valid), .dsp_instr(dsp_instr),
  .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
);

// File: tb/sim_dispatch_stage.sv
`timescale 1ns/1ps
module sim_dispatch_stage;
  localparam int MAX_W = 4, NSCH = 3, FREE_W = 8, CNT_W = 4, IW = 18, NV = 21;
  localparam int NONE = 7;

  typedef struct packed {
    logic [3:0][9:0] sl;
    logic [3:0] rob, rg, c0, c1, c2, lq, sq;
    logic [2:0] cw;
    logic       pn;
    logic [2:0] tk, up, ca;
  } vec_t;

  // slot code {valid, ld, st, solo, sched[1:0], nregs[1:0], uops-1[1:0]}
  function automatic logic [9:0] sl(int u, int r, int s, int ld, int st, int so);
    logic [31:0] um, rr, ss, a, b, c;
    um = u - 1; rr = r; ss = s; a = ld; b = st; c = so;
    return {1'b1, a[0], b[0], c[0], ss[1:0], rr[1:0], um[1:0]};
  endfunction

  function automatic logic [9:0] one();
    return sl(1, 1, 0, 0, 0, 0);
  endfunction

  function automatic vec_t mk(logic [9:0] a, logic [9:0] b, logic [9:0] c, logic [9:0] d,
                              int rob, int rg, int c0, int c1, int c2, int lq, int sq,
                              int cw, int pn, int tk, int up, int ca);
    vec_t v;
    v.sl[0] = a; v.sl[1] = b; v.sl[2] = c; v.sl[3] = d;
    v.rob = 4'(rob); v.rg = 4'(rg); v.c0 = 4'(c0); v.c1 = 4'(c1); v.c2 = 4'(c2);
    v.lq = 4'(lq); v.sq = 4'(sq); v.cw = 3'(cw); v.pn = 1'(pn);
    v.tk = 3'(tk); v.up = 3'(up); v.ca = 3'(ca);
    return v;
  endfunction

  localparam vec_t TBL [NV] = '{
    mk(one(), one(), one(), one(),            15,15,15,15,15,15,15, 4,1, 4,4,NONE), // R2 all fit
    mk(sl(2,1,0,0,0,0), sl(2,1,0,0,0,0), one(), 10'd0,
                                              15,15,15,15,15,15,15, 4,1, 2,4,NONE), // R2 width
    mk(one(), one(), one(), one(),             3,15,15,15,15,15,15, 4,1, 3,3,1),    // R3 rob
    mk(one(), one(), one(), one(),            15, 2,15,15,15,15,15, 4,1, 2,2,0),    // R2 reg
    mk(one(), one(), one(), one(),            15, 0,15,15,15,15,15, 4,0, 4,4,NONE), // R5 unlimited
    mk(sl(1,1,1,0,0,0), sl(1,1,1,0,0,0), 10'd0, 10'd0,
                                              15,15,15, 1,15,15,15, 4,1, 1,1,2),    // R2 sched
    mk(sl(1,1,0,1,0,0), sl(1,1,0,1,0,0), 10'd0, 10'd0,
                                              15,15,15,15,15, 1,15, 4,1, 1,1,3),    // R2 lq
    mk(sl(1,1,0,0,1,0), one(), 10'd0, 10'd0,  15,15,15,15,15,15, 0, 4,1, 0,0,4),    // R2 sq
    mk(one(), sl(1,1,0,0,0,1), one(), 10'd0,  15,15,15,15,15,15,15, 4,1, 1,1,5),    // R8 solo late
    mk(sl(1,1,0,0,0,1), one(), 10'd0, 10'd0,  15,15,15,15,15,15,15, 4,1, 1,1,5),    // R8 solo first
    mk(one(), one(), 10'd0, 10'd0,             1, 1, 1,15,15,15,15, 4,1, 1,1,0),    // R7 reg wins
    mk(one(), sl(1,1,0,1,0,0), 10'd0, 10'd0,   1,15, 1,15,15, 0,15, 4,1, 1,1,1),    // R7 rob wins
    mk(one(), one(), one(), one(),            15,15,15,15,15,15,15, 0,1, 2,2,NONE), // R4 default
    mk(one(), sl(1,1,1,0,0,0), one(), 10'd0,  15,15,15, 0,15,15,15, 4,1, 1,1,2),    // R1 in order
    mk(sl(4,1,0,0,0,0), one(), 10'd0, 10'd0,  15,15,15,15,15,15,15, 2,1, 1,4,NONE), // R2 oversize
    mk(10'd0, 10'd0, 10'd0, 10'd0,            15,15,15,15,15,15,15, 4,1, 0,0,NONE), // R6 empty
    mk(one(), 10'd0, one(), 10'd0,            15,15,15,15,15,15,15, 4,1, 1,1,NONE), // R1 gap
    mk(sl(2,1,2,0,0,0), sl(2,1,2,0,0,0), 10'd0, 10'd0,
                                              15,15,15,15, 3,15,15, 4,1, 1,2,2),    // R2 sched uops
    mk(one(), sl(2,1,0,0,0,0), one(), 10'd0,  15,15,15,15,15,15,15, 3,1, 2,3,NONE), // R2 width exact
    mk(one(), sl(2,1,0,0,0,0), one(), 10'd0,   3,15,15,15,15,15,15, 3,1, 2,3,NONE), // R6 width first
    mk(one(), one(), one(), one(),            15,15,15,15,15,15,15, 7,1, 4,4,NONE)  // R4 clamp
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]              cfg_width = 3'd4;
  logic [FREE_W-1:0]       cfg_prf_size = 8'd64;
  logic [MAX_W-1:0]        in_valid = '0;
  logic [MAX_W*IW-1:0]     in_instr = '0;
  logic [2:0]              in_take;
  logic [FREE_W-1:0]       rob_free = 8'd15, reg_free = 8'd15, lq_free = 8'd15, sq_free = 8'd15;
  logic [NSCH*FREE_W-1:0]  sched_free = {3{8'd15}};
  logic [MAX_W-1:0]        dsp_valid;
  logic [MAX_W*IW-1:0]     dsp_instr;
  logic [6*CNT_W-1:0]      stall_cnt;
  logic [(MAX_W+1)*CNT_W-1:0] hist_cnt;

  int n_chk = 0, n_err = 0;
  int exp_s [6];
  int exp_h [MAX_W+1];

  always #2 clk = ~clk;

  dispatch_stage #(.MAX_W(MAX_W), .DEF_W(2), .NSCH(NSCH), .FREE_W(FREE_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_prf_size(cfg_prf_size),
    .in_valid(in_valid), .in_instr(in_instr), .in_take(in_take),
    .rob_free(rob_free), .reg_free(reg_free), .sched_free(sched_free),
    .lq_free(lq_free), .sq_free(sq_free), .dsp_valid(dsp_valid), .dsp_instr(dsp_instr),
    .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(vec_t t, int v);
    for (int j = 0; j < MAX_W; j++) begin
      logic [7:0] tg;
      logic [2:0] u;
      tg = 8'(v * 4 + j);
      u  = {1'b0, t.sl[j][1:0]} + 3'd1;
      in_valid[j] = t.sl[j][9];
      in_instr[j*IW +: IW] = {tg, u, t.sl[j][3:2], t.sl[j][5:4], t.sl[j][8], t.sl[j][7], t.sl[j][6]};
    end
    rob_free = 8'(t.rob); reg_free = 8'(t.rg); lq_free = 8'(t.lq); sq_free = 8'(t.sq);
    sched_free = {8'(t.c2), 8'(t.c1), 8'(t.c0)};
    cfg_width = t.cw;
    cfg_prf_size = t.pn ? 8'd64 : 8'd0;
  endtask

  task automatic chk_counters(string req);
    for (int k = 0; k < 6; k++)
      chk(int'(stall_cnt[k*CNT_W +: CNT_W]) == exp_s[k], req, int'(stall_cnt[k*CNT_W +: CNT_W]), exp_s[k]);
    for (int b = 0; b <= MAX_W; b++)
      chk(int'(hist_cnt[b*CNT_W +: CNT_W]) == exp_h[b], req, int'(hist_cnt[b*CNT_W +: CNT_W]), exp_h[b]);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) exp_s[k] = 0;
    for (int b = 0; b <= MAX_W; b++) exp_h[b] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(dsp_valid == '0, "R10 reset bus", int'(dsp_valid), 0);
    chk_counters("R10 reset counters");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rst = 1'b0;
      drive(TBL[v], v);
      #1;
      chk(in_take == TBL[v].tk, $sformatf("R1/R2 take vec%0d", v), int'(in_take), int'(TBL[v].tk));
      @(posedge clk);
      #1;
      chk($countones(dsp_valid) == int'(TBL[v].tk), $sformatf("R11 bus count vec%0d", v),
          $countones(dsp_valid), int'(TBL[v].tk));
      for (int j = 0; j < int'(TBL[v].tk); j++)
        chk(dsp_valid[j] && dsp_instr[j*IW+10 +: 8] == 8'(v*4+j), $sformatf("R11 tag vec%0d", v),
            int'(dsp_instr[j*IW+10 +: 8]), v*4+j);
      if (TBL[v].ca != 3'(NONE)) exp_s[TBL[v].ca]++;
      exp_h[(TBL[v].up > 3'(MAX_W)) ? MAX_W : int'(TBL[v].up)]++;
    end
    chk_counters("R6/R7/R9 totals");

    // R10 synchronous reset clears, then saturation under a held rob shortage
    @(negedge clk);
    rst = 1'b1;
    drive(mk(one(), 10'd0, 10'd0, 10'd0, 0,15,15,15,15,15,15, 4,1, 0,0,1), 0);
    @(posedge clk);
    #1;
    for (int k = 0; k < 6; k++) exp_s[k] = 0;
    for (int b = 0; b <= MAX_W; b++) exp_h[b] = 0;
    chk(dsp_valid == '0, "R10 mid reset bus", int'(dsp_valid), 0);
    chk_counters("R10 mid reset counters");
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(in_take == 3'd0, "R3 rob empty take", int'(in_take), 0);
    repeat (20) @(posedge clk);
    #1;
    exp_s[1] = 15;
    exp_h[0] = 15;
    chk_counters("R10 saturation");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule